// File: doc/BRIEF.md
# Quadrature Counter with Dual Preload

This block is one 24-bit up/down counter channel. It counts the edges of an incremental encoder, pulses on a single phase line, or its own clock. Direction comes either from the phase order of the two encoder lines or from a mode bit. Counting is enabled by software or by a hardware condition. That condition can be an external enable pin, the index line, an index-armed start, or the absence of a pending rollover.

Two preload registers feed automatic reloads. The register used for a reload is picked by a flag that toggles on every rollover. This lets the channel act as a retriggerable one-shot or a PWM generator with no software in the loop. The high word of a preload is staged until the low word arrives, so 24-bit values stay coherent over the 16-bit port. Count readout goes through a holding register. That register is loaded either by a read of the low word or by a hardware event.

Short events are kept in sticky flags: rollover, index rising edge, index falling edge and illegal phase step. These flags drive an interrupt request and a configurable output pin.

Top module: `quad_preload_counter`

## Requirements
- R1: After reset the count, holding register, both preloads, the rollover toggle, all flags, the mode and control fields are zero, so `cnt_out` and `irq` are 0.
- R2: With mode bit 12 set (quadrature) and clock field [10:9]=1x, every single-bit step of (A,B) counts; the sequence 00→01→11→10→00 counts up and its reverse counts down, wrapping through 0xFFFFFF.
- R3: In quadrature mode, clock field 00 counts once per full phase cycle (A rising when moving up, A falling when moving down); field 01 counts both A edges.
- R4: In quadrature mode a step where A and B change together does not change the count and sets the error flag (status bit 3).
- R5: With mode bit 12 clear, clock field 00 counts A rising edges, 01 A falling edges, 10 every clock and 11 every second clock; mode bit 11 selects down (1) or up (0).
- R6: Enable field [3:2]: 00 off, 01 on, 10 hardware source, 11 hardware source inverted; source field [5:4]: 00 enable pin, 01 index level, 10 armed start, 11 rollover flag clear.
- R7: Counting past the limit in the current direction sets the sticky rollover flag (status bit 0) and toggles the reload toggle (status bit 12).
- R8: An automatic reload, enabled by mode bits 6 (rollover), 7 (index rise) and 8 (index fall), loads preload 0 when the toggle is 0 and preload 1 when it is 1, and clears the rollover flag unless a rollover occurs in the same cycle.
- R9: A write to address 1 only stages the high byte; the preload chosen by mode bit 14 takes {staged byte, data} when address 0 is written.
- R10: With mode bit 13 clear, reading address 0 returns the live count low word and copies the count to the holding register read at address 1; with bit 13 set, reads latch nothing and the latch fires on `latch_strobe` or on index edges selected by control bits 10 (rise) and 11 (fall).
- R11: A control write (address 3) with bit 15 clears the count and toggle, bit 14 loads preload 0, bit 13 re-arms the index start.
- R12: Control bits [3:0] written as 1 clear rollover, index-rise, index-fall and error flags; `irq` is high while any flag is set whose enable in control bits [9:6] (same order) is 1.
- R13: `cnt_out` is the rollover flag (mode bit 0 = 0) or the toggle (bit 0 = 1), inverted when mode bit 1 is set; status bits 4 and 5 read `cnt_out` and the synchronized index level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; also the internal count clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| rd_en | input | 1 | Single-cycle register read strobe |
| addr | input | 2 | Word address: 0 data/preload low, 1 high, 2 mode, 3 control/status |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid in the strobe cycle |
| enc_a | input | 1 | Encoder phase A / pulse input |
| enc_b | input | 1 | Encoder phase B |
| enc_idx | input | 1 | Index input |
| enc_ce | input | 1 | External count enable |
| latch_strobe | input | 1 | Timer expiry strobe for event latching |
| cnt_out | output | 1 | Configurable output pin |
| irq | output | 1 | Interrupt request |

## Verification
Encoder, index and enable pins pass two synchronizer flops, so a level applied between edges first changes the count at the third following rising edge. The bench waits exactly three cycles after each such change before reading. A register write takes effect at the edge that samples it, and internal-clock counting starts one edge later. The bench therefore predicts internal-clock counts as the number of edges between the write and the sampling point. Reads are combinational in the strobe cycle; the low word reflects the count before the edge and the high word comes from the holding register loaded at that edge. Checks sample outputs just after a falling edge.

// File: rtl/quad_preload_counter.sv
module quad_preload_counter #(
  parameter int CW = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [1:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  input  logic        enc_a,
  input  logic        enc_b,
  input  logic        enc_idx,
  input  logic        enc_ce,
  input  logic        latch_strobe,
  output logic        cnt_out,
  output logic        irq
);
  localparam int HW = CW - 16;
  localparam logic [CW-1:0] CMAX = '1;

  logic [3:0] s1, s2;
  logic [2:0] s3;
  logic [CW-1:0] count, hold, pr0, pr1;
  logic [HW-1:0] stage;
  logic [14:0] mode;
  logic [5:0]  cfg;
  logic [3:0]  flags;
  logic rtgl, run, div;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= {enc_ce, enc_idx, enc_b, enc_a};
      s2 <= s1;
      s3 <= s2[2:0];
    end
  end

  wire a_cur = s2[0], b_cur = s2[1], i_cur = s2[2], ce_in = s2[3];
  wire a_prv = s3[0], b_prv = s3[1], i_prv = s3[2];
  wire idx_rise = i_cur & ~i_prv;
  wire idx_fall = ~i_cur & i_prv;
  wire a_edge = a_cur ^ a_prv;
  wire b_edge = b_cur ^ b_prv;
  wire q_err  = a_edge & b_edge;
  wire q_up   = a_prv ^ b_cur;

  wire       m_osel = mode[0];
  wire       m_oinv = mode[1];
  wire [1:0] m_ce   = mode[3:2];
  wire [1:0] m_hws  = mode[5:4];
  wire [2:0] m_al   = mode[8:6];
  wire [1:0] m_clk  = mode[10:9];
  wire       m_down = mode[11];
  wire       m_quad = mode[12];
  wire       m_levt = mode[13];
  wire       m_psel = mode[14];

  wire ctl_wr  = wr_en && addr == 2'd3;
  wire cmd_clr = ctl_wr & wdata[15];
  wire cmd_ld  = ctl_wr & wdata[14];
  wire cmd_arm = ctl_wr & wdata[13];

  logic tick, up, hw_en;
  always_comb begin
    if (m_quad) begin
      up = q_up;
      case (m_clk)
        2'b00:   tick = a_edge & ~b_edge & (q_up ? a_cur : ~a_cur);
        2'b01:   tick = a_edge & ~b_edge;
        default: tick = a_edge ^ b_edge;
      endcase
    end else begin
      up = ~m_down;
      case (m_clk)
        2'b00:   tick = a_cur & ~a_prv;
        2'b01:   tick = ~a_cur & a_prv;
        2'b10:   tick = 1'b1;
        default: tick = div;
      endcase
    end
    case (m_hws)
      2'b00:   hw_en = ce_in;
      2'b01:   hw_en = i_cur;
      2'b10:   hw_en = run;
      default: hw_en = ~flags[0];
    endcase
  end

  wire cnt_en  = (m_ce == 2'b01) | (m_ce[1] & (hw_en ^ m_ce[0]));
  wire step    = tick & cnt_en;
  wire at_lim  = up ? (count == CMAX) : (count == '0);
  wire no_cmd  = ~cmd_clr & ~cmd_ld;
  wire ro      = step & at_lim & no_cmd;
  wire auto_ld = no_cmd & ((m_al[0] & ro) | (m_al[1] & idx_rise) | (m_al[2] & idx_fall));
  wire rd_lat  = rd_en && addr == 2'd0 && !m_levt;
  wire ev_lat  = m_levt & (latch_strobe | (cfg[4] & idx_rise) | (cfg[5] & idx_fall));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0; rtgl <= 1'b0; flags <= '0; run <= 1'b0; div <= 1'b0;
      hold <= '0; pr0 <= '0; pr1 <= '0; stage <= '0; mode <= '0; cfg <= '0;
    end else begin
      div <= ~div;
      if (cmd_clr)      count <= '0;
      else if (cmd_ld)  count <= pr0;
      else if (auto_ld) count <= rtgl ? pr1 : pr0;
      else if (step)    count <= up ? count + 1'b1 : count - 1'b1;
      if (cmd_clr) rtgl <= 1'b0;
      else if (ro) rtgl <= ~rtgl;
      flags <= (flags & ~(ctl_wr ? wdata[3:0] : 4'b0) & ~{3'b0, auto_ld})
             | {q_err & m_quad, idx_fall, idx_rise, ro};
      if (cmd_arm) run <= 1'b0;
      else if (idx_rise) run <= 1'b1;
      if (rd_lat || ev_lat) hold <= count;
      if (wr_en) begin
        case (addr)
          2'd0: if (m_psel) pr1 <= {stage, wdata}; else pr0 <= {stage, wdata};
          2'd1: stage <= wdata[HW-1:0];
          2'd2: mode <= wdata[14:0];
          default: cfg <= wdata[11:6];
        endcase
      end
    end
  end

  assign cnt_out = (m_osel ? rtgl : flags[0]) ^ m_oinv;
  assign irq     = |(flags & cfg[3:0]);

  always_comb begin
    case (addr)
      2'd0:    rdata = rd_lat ? count[15:0] : hold[15:0];
      2'd1:    rdata = {{(16-HW){1'b0}}, hold[CW-1:16]};
      2'd2:    rdata = {1'b0, mode};
      default: rdata = {3'b0, rtgl, cfg, i_cur, cnt_out, flags};
    endcase
  end

  AST_CLEAR_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clr |=> (count == '0) && !rtgl); // R11
  AST_LOAD_PR0: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ld && !cmd_clr) |=> count == $past(pr0)); // R11
  AST_RTGL_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ro |=> rtgl != $past(rtgl)); // R7
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_quad && q_err && no_cmd && !auto_ld) |=> $stable(count)); // R4
  AST_STAGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1) |=> $stable(pr0) && $stable(pr1)); // R9
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != 4'b0)); // R12
endmodule

// File: tb/tb_quad_preload_counter.sv
module tb_quad_preload_counter;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0, enc_ce = 1'b0, latch_strobe = 1'b0;
  logic cnt_out, irq;
  int n_chk = 0, n_err = 0;

  quad_preload_counter dut (.*);

  always #5 clk = ~clk;

  // {A, B, expected count} for x4 quadrature steps
  localparam logic [25:0] QTAB [10] = '{
    26'h1000001, 26'h3000002, 26'h2000003, 26'h0000004, 26'h2000003,
    26'h3000002, 26'h1000001, 26'h0000000, 26'h2FFFFFF, 26'h0000000};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd16(input logic [1:0] a, output logic [15:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic read24(output logic [23:0] v);
    logic [15:0] lo, hi;
    rd16(2'd0, lo);
    rd16(2'd1, hi);
    v = {hi[7:0], lo};
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [23:0] v;
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    read24(v);      chk("R1 count", {8'h0, v}, 32'h0);
    rd16(2'd3, d);  chk("R1 status", {16'h0, d}, 32'h0);
    chk("R1 irq/out", {30'h0, irq, cnt_out}, 32'h0);

    wr(2'd2, 16'h1404);
    foreach (QTAB[i]) begin
      {enc_a, enc_b} = QTAB[i][25:24];
      settle();
      read24(v);
      chk("R2 x4 step", {8'h0, v}, {8'h0, QTAB[i][23:0]});
    end
    rd16(2'd3, d);  chk("R7 R13 rollover flag and pin", {16'h0, d}, 32'h0011);
    wr(2'd3, 16'h0001);
    rd16(2'd3, d);  chk("R12 clear rollover", {28'h0, d[3:0]}, 32'h0);

    {enc_a, enc_b} = 2'b11; settle();
    read24(v);      chk("R4 error no count", {8'h0, v}, 32'h0);
    rd16(2'd3, d);  chk("R4 error flag", {31'h0, d[3]}, 32'h1);
    {enc_a, enc_b} = 2'b00; settle();
    wr(2'd3, 16'h0008);
    rd16(2'd3, d);  chk("R12 clear error", {28'h0, d[3:0]}, 32'h0);

    wr(2'd2, 16'h0000); wr(2'd3, 16'h8000); wr(2'd2, 16'h1004);
    {enc_a, enc_b} = 2'b01; settle(); {enc_a, enc_b} = 2'b11; settle();
    {enc_a, enc_b} = 2'b10; settle(); {enc_a, enc_b} = 2'b00; settle();
    read24(v);      chk("R3 x1 cycle", {8'h0, v}, 32'h1);
    wr(2'd2, 16'h1204);
    {enc_a, enc_b} = 2'b01; settle(); {enc_a, enc_b} = 2'b11; settle();
    {enc_a, enc_b} = 2'b10; settle(); {enc_a, enc_b} = 2'b00; settle();
    read24(v);      chk("R3 x2 cycle", {8'h0, v}, 32'h3);

    wr(2'd2, 16'h0000); wr(2'd3, 16'h8000); wr(2'd2, 16'h0404);
    repeat (10) @(negedge clk);
    rd16(2'd0, d);  chk("R5 internal up", {16'h0, d}, 32'd10);
    wr(2'd2, 16'h0000); wr(2'd3, 16'h8000); wr(2'd2, 16'h0C04);
    repeat (3) @(negedge clk);
    read24(v);      chk("R5 internal down", {8'h0, v}, 32'hFFFFFD);
    wr(2'd2, 16'h0000); wr(2'd3, 16'h800F); wr(2'd2, 16'h0604);
    repeat (10) @(negedge clk);
    rd16(2'd0, d);  chk("R5 half rate", {16'h0, d}, 32'd5);
    wr(2'd2, 16'h0000); wr(2'd3, 16'h8000); wr(2'd2, 16'h0004);
    enc_a = 1'b1; settle(); enc_a = 1'b0; settle();
    enc_a = 1'b1; settle(); enc_a = 1'b0; settle();
    rd16(2'd0, d);  chk("R5 A rising edges", {16'h0, d}, 32'd2);

    wr(2'd2, 16'h0000); wr(2'd3, 16'h8000); wr(2'd2, 16'h0408);
    repeat (10) @(negedge clk);
    rd16(2'd0, d);  chk("R6 pin low disables", {16'h0, d}, 32'd0);
    wr(2'd2, 16'h0000); enc_ce = 1'b1; settle(); wr(2'd2, 16'h040C);
    repeat (10) @(negedge clk);
    rd16(2'd0, d);  chk("R6 inverted pin high disables", {16'h0, d}, 32'd0);
    wr(2'd2, 16'h0000); enc_ce = 1'b0; settle(); wr(2'd2, 16'h040C);
    repeat (10) @(negedge clk);
    rd16(2'd0, d);  chk("R6 inverted pin low enables", {16'h0, d}, 32'd10);

    wr(2'd2, 16'h0000); wr(2'd3, 16'h8000); wr(2'd2, 16'h0428); wr(2'd3, 16'h2000);
    repeat (10) @(negedge clk);
    rd16(2'd0, d);  chk("R11 armed waits", {16'h0, d}, 32'd0);
    enc_idx = 1'b1; repeat (10) @(negedge clk);
    rd16(2'd0, d);  chk("R6 index starts count", {31'h0, d != 16'h0}, 32'h1);
    rd16(2'd3, d);  chk("R13 index live and rise flag", {16'h0, d & 16'h0022}, 32'h0022);
    enc_idx = 1'b0; settle();
    rd16(2'd3, d);  chk("R12 index fall flag", {31'h0, d[2]}, 32'h1);

    wr(2'd2, 16'h0000); wr(2'd3, 16'h800F);
    wr(2'd1, 16'h0012); wr(2'd0, 16'h3456);
    wr(2'd2, 16'h4000); wr(2'd1, 16'h00AB);
    wr(2'd2, 16'h0000); wr(2'd3, 16'h4000);
    read24(v);      chk("R9 staged high byte", {8'h0, v}, 32'h123456);

    wr(2'd1, 16'h0000); wr(2'd0, 16'h0002);
    wr(2'd2, 16'h4000); wr(2'd1, 16'h0000); wr(2'd0, 16'h0004);
    wr(2'd2, 16'h0000); wr(2'd3, 16'h800F); wr(2'd3, 16'h4000);
    wr(2'd2, 16'h0C44);
    repeat (3) @(negedge clk);
    read24(v);      chk("R8 reload from preload 0", {8'h0, v}, 32'h2);
    rd16(2'd3, d);  chk("R7 toggle set", {31'h0, d[12]}, 32'h1);
    rd16(2'd0, d);  chk("R8 reload from preload 1", {16'h0, d}, 32'h4);
    rd16(2'd3, d);  chk("R7 toggle back", {31'h0, d[12]}, 32'h0);

    wr(2'd2, 16'h0000);
    wr(2'd1, 16'h0000); wr(2'd0, 16'h0003);
    wr(2'd2, 16'h4000); wr(2'd1, 16'h0000); wr(2'd0, 16'h0003);
    wr(2'd2, 16'h0000); wr(2'd3, 16'h800F); wr(2'd3, 16'h4000);
    wr(2'd2, 16'h0CBA);
    chk("R13 pulse active", {31'h0, cnt_out}, 32'h1);
    repeat (10) @(negedge clk);
    read24(v);      chk("R7 one-shot stops", {8'h0, v}, 32'hFFFFFF);
    chk("R13 pulse ended", {31'h0, cnt_out}, 32'h0);
    enc_idx = 1'b1; repeat (20) @(negedge clk);
    read24(v);      chk("R8 retrigger ran", {8'h0, v}, 32'hFFFFFF);
    rd16(2'd3, d);  chk("R8 second shot toggled", {31'h0, d[12]}, 32'h0);
    enc_idx = 1'b0; settle();
    wr(2'd2, 16'h0000); chk("R13 pin shows flag", {31'h0, cnt_out}, 32'h1);
    wr(2'd2, 16'h0001); chk("R13 pin shows toggle", {31'h0, cnt_out}, 32'h0);
    wr(2'd2, 16'h0003); chk("R13 pin inverted", {31'h0, cnt_out}, 32'h1);

    wr(2'd2, 16'h0000); wr(2'd3, 16'h800F); wr(2'd2, 16'h2404);
    repeat (5) @(negedge clk);
    latch_strobe = 1'b1; @(negedge clk); latch_strobe = 1'b0;
    repeat (3) @(negedge clk);
    rd16(2'd0, d);  chk("R10 strobe latch", {16'h0, d}, 32'd5);
    rd16(2'd0, d);  chk("R10 read does not latch", {16'h0, d}, 32'd5);
    wr(2'd3, 16'h0400);
    enc_idx = 1'b1; settle();
    rd16(2'd0, d);  chk("R10 index latch", {31'h0, d != 16'd5}, 32'h1);
    enc_idx = 1'b0; settle();

    wr(2'd2, 16'h0000); wr(2'd3, 16'h800F);
    wr(2'd2, 16'h0C04); wr(2'd2, 16'h0000);
    chk("R12 masked irq", {31'h0, irq}, 32'h0);
    wr(2'd3, 16'h0040); chk("R12 irq on rollover", {31'h0, irq}, 32'h1);
    wr(2'd3, 16'h0041); chk("R12 irq cleared", {31'h0, irq}, 32'h0);
    wr(2'd3, 16'h0080); enc_idx = 1'b1; settle();
    chk("R12 irq on index rise", {31'h0, irq}, 32'h1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule